// File: doc/BRIEF.md
# Transmit Packet RAM Loader

This block moves an outgoing frame from a local byte buffer into a radio transceiver's transmit packet RAM over a four-wire SPI link. A single `start` pulse with a byte count sets off three SPI transactions, each framed by its own chip-select window.

The first transaction reads the transceiver's 16-bit length register. The second writes that register back. In the written value, only the 7-bit frame-length field changes: it becomes the payload length plus two, which leaves room for the CRC that the transceiver appends. The third transaction is a burst. It starts with the packet RAM address byte and then streams the payload as 16-bit words. Within each word, the odd-indexed byte goes out first.

The buffer is read through a synchronous port with one cycle of latency. When the burst has finished, `done` pulses for one cycle. A length that would overflow the 7-bit field is refused at once: `err` and `done` pulse together and no SPI traffic takes place.

Top module: `pkt_ram_loader`

## Requirements
- R1: After reset and whenever idle, `cs_n` is high, `sclk` is low, and `busy` and `done` are low.
- R2: An accepted start first runs one chip-select window of three bytes. The first byte is `1` (read flag), `0`, then the 6-bit length-register address. The register value is captured MSB first from the next two bytes.
- R3: The second window sends the address byte with bit 7 clear, then the register's upper byte, then a byte holding the register's bit 7 followed by the 7-bit value (length + 2). The register's upper 9 bits are returned unchanged.
- R4: The third window begins with the byte `00` followed by the 6-bit packet RAM address, and it stays in a single chip-select window until the last payload byte.
- R5: The burst carries (length + 1) >> 1 words, which is 2 × that count payload bytes after the address byte. A length of 0 sends the address byte alone.
- R6: For word k, buffer byte 2k+1 is sent first and buffer byte 2k second.
- R7: When the length is odd, the first-sent byte of the last word is zero.
- R8: Data received on `miso` during the write and burst windows has no effect on the bytes sent.
- R9: A start with length above 125 is answered one cycle later by a single cycle with `err` and `done` both high. `cs_n` stays high throughout. A start with length of 125 or less never raises `err`.
- R10: SPI mode 0 is used: `sclk` rises only while `cs_n` is low, `mosi` is stable across each rising edge, and bytes go MSB first.
- R11: `busy` is high from the cycle after an accepted start until `done`, and `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load; sampled while idle |
| len | input | LEN_W | Payload byte count |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Length rejected (pulses with done) |
| buf_addr | output | BUF_AW | Buffer read address |
| buf_rdata | input | 8 | Buffer read data, one cycle after address |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |

## Verification
The bench runs the load at lengths 0, 1, 2, 5, 8, 17 and 125, and at each it compares every byte of all three chip-select windows. Even and odd lengths together show whether the word count rounds up and whether the padded byte is zero. A buffer pattern that is different at every index exposes any swapped or shifted pair. The bench's modelled length register is given an arbitrary upper 9 bits and is updated after each write, so a lost or corrupted upper bit carries into the next run. `miso` keeps toggling during the burst, and lengths 126 and 255 exercise the refusal path.

// File: rtl/pkt_loader_pkg.sv
package pkt_loader_pkg;

    localparam int FIELD_W = 7;
    localparam int REG_AW  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEND,
        ST_SHIFT,
        ST_GAP
    } ld_state_e;

    typedef enum logic [1:0] {
        PH_REG_READ,
        PH_REG_WRITE,
        PH_BURST
    } ld_phase_e;

    function automatic logic [7:0] cmd_byte(input logic rd, input logic [REG_AW-1:0] a);
        return {rd, 1'b0, a};
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LIM = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;
    logic          active;

    assign mosi = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            bitn      <= '0;
            sh        <= '0;
            rx_byte   <= '0;
            active    <= 1'b0;
            sclk      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (go && !active) begin
                sh     <= tx_byte;
                active <= 1'b1;
                cnt    <= '0;
                bitn   <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (cnt == LIM) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pkt_byte_picker.sv
module pkt_byte_picker
    import pkt_loader_pkg::*;
#(
    parameter int              LEN_W  = 8,
    parameter int              BUF_AW = 7,
    parameter logic [REG_AW-1:0] LEN_REG_A = 6'h03,
    parameter logic [REG_AW-1:0] RAM_A     = 6'h02
) (
    input  ld_phase_e          ph,
    input  logic [LEN_W:0]     idx,
    input  logic [LEN_W-1:0]   len_q,
    input  logic [15:0]        old_reg,
    input  logic [7:0]         buf_rdata,
    output logic [BUF_AW-1:0]  buf_addr,
    output logic [7:0]         tx_byte
);
    logic [LEN_W:0]   src;
    logic             in_range;
    logic [LEN_W-1:0] sum;

    always_comb begin
        src      = idx[0] ? idx : idx - (LEN_W+1)'(2);
        in_range = src < {1'b0, len_q};
        sum      = len_q + LEN_W'(2);
        buf_addr = src[BUF_AW-1:0];
        case (ph)
            PH_REG_READ:  tx_byte = (idx == '0) ? cmd_byte(1'b1, LEN_REG_A) : 8'h00;
            PH_REG_WRITE: begin
                if (idx == '0)
                    tx_byte = cmd_byte(1'b0, LEN_REG_A);
                else if (idx == (LEN_W+1)'(1))
                    tx_byte = old_reg[15:8];
                else
                    tx_byte = {old_reg[7], sum[FIELD_W-1:0]};
            end
            default: begin
                if (idx == '0)
                    tx_byte = cmd_byte(1'b0, RAM_A);
                else
                    tx_byte = in_range ? buf_rdata : 8'h00;
            end
        endcase
    end
endmodule

// File: rtl/pkt_ram_loader.sv
module pkt_ram_loader
    import pkt_loader_pkg::*;
#(
    parameter int              LEN_W     = 8,
    parameter int              BUF_AW    = 7,
    parameter int              HALF      = 2,
    parameter int              MAX_LEN   = 125,
    parameter logic [5:0]      LEN_REG_A = 6'h03,
    parameter logic [5:0]      RAM_A     = 6'h02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int IDX_W = LEN_W + 1;

    ld_state_e        st;
    ld_phase_e        ph;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [LEN_W-1:0] len_q;
    logic [15:0]      old_reg;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic             byte_done;
    logic             go;

    assign busy = (st != ST_IDLE);
    assign go   = (st == ST_SEND);

    always_comb begin
        if (ph == PH_BURST)
            last_idx = {1'b0, len_q} + IDX_W'(len_q[0]);
        else
            last_idx = IDX_W'(2);
    end

    pkt_byte_picker #(
        .LEN_W(LEN_W), .BUF_AW(BUF_AW), .LEN_REG_A(LEN_REG_A), .RAM_A(RAM_A)
    ) u_pick (
        .ph(ph), .idx(idx), .len_q(len_q), .old_reg(old_reg),
        .buf_rdata(buf_rdata), .buf_addr(buf_addr), .tx_byte(tx_byte)
    );

    spi_byte_shifter #(.HALF(HALF)) u_shift (
        .clk(clk), .rst(rst), .go(go), .tx_byte(tx_byte), .miso(miso),
        .sclk(sclk), .mosi(mosi), .rx_byte(rx_byte), .byte_done(byte_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ph      <= PH_REG_READ;
            idx     <= '0;
            len_q   <= '0;
            old_reg <= '0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (int'(len) > MAX_LEN) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else begin
                            len_q <= len;
                            ph    <= PH_REG_READ;
                            idx   <= '0;
                            cs_n  <= 1'b0;
                            st    <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: st <= ST_SEND;
                ST_SEND: st <= ST_SHIFT;
                ST_SHIFT: begin
                    if (byte_done) begin
                        if (ph == PH_REG_READ) begin
                            if (idx == IDX_W'(1)) old_reg[15:8] <= rx_byte;
                            if (idx == IDX_W'(2)) old_reg[7:0]  <= rx_byte;
                        end
                        if (idx == last_idx) begin
                            cs_n <= 1'b1;
                            if (ph == PH_BURST) begin
                                done <= 1'b1;
                                st   <= ST_IDLE;
                            end else begin
                                st <= ST_GAP;
                            end
                        end else begin
                            idx <= idx + IDX_W'(1);
                            st  <= ST_LOAD;
                        end
                    end
                end
                ST_GAP: begin
                    ph   <= (ph == PH_REG_READ) ? PH_REG_WRITE : PH_BURST;
                    idx  <= '0;
                    cs_n <= 1'b0;
                    st   <= ST_LOAD;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pkt_ram_loader_chk.sv
module pkt_ram_loader_chk #(
    parameter int LEN_W   = 8,
    parameter int MAX_LEN = 125
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [LEN_W-1:0] len,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             sclk,
    input logic             cs_n,
    input logic             mosi
);
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);                                              // R1
    AST_SCLK_SELECTED: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> !cs_n);                                       // R10
    AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(mosi));                               // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                              // R11
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && cs_n));                                      // R9
    AST_LEN_REJECT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && int'(len) > MAX_LEN) |=> err);             // R9
    AST_LEN_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && int'(len) <= MAX_LEN) |=> (busy && !err)); // R11
endmodule

bind pkt_ram_loader pkt_ram_loader_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
    .clk(clk), .rst(rst), .start(start), .len(len), .busy(busy), .done(done),
    .err(err), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/pkt_ram_loader_tb.sv
module pkt_ram_loader_tb;
    localparam logic [5:0] LA = 6'h03;
    localparam logic [5:0] RA = 6'h02;
    localparam int NVEC = 7;
    localparam int VEC_LEN [NVEC] = '{1, 2, 5, 8, 17, 0, 125};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] len = '0;
    logic busy, done, err, sclk, cs_n, mosi, miso;
    logic [6:0] buf_addr;
    logic [7:0] buf_rdata;
    logic [7:0] mem [0:127];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pkt_ram_loader u_dut (
        .clk(clk), .rst(rst), .start(start), .len(len), .busy(busy), .done(done),
        .err(err), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always @(posedge clk) buf_rdata <= mem[buf_addr];

    // SPI target model: logs every byte, answers length-register reads
    logic [15:0] slv_reg = 16'hB6D5;
    logic [15:0] miso_sh = 16'hA53C;
    logic [7:0]  sh_in   = '0;
    logic [7:0]  log_b [0:511];
    int tr_first [0:7];
    int nb = 0, ntr = 0, bitc = 0;
    assign miso = miso_sh[15];

    always @(negedge cs_n or posedge sclk) begin
        if (!sclk) begin
            if (ntr < 8) tr_first[ntr] = nb;
            ntr  = ntr + 1;
            bitc = 0;
            miso_sh = 16'hA53C;
        end else if (!cs_n) begin
            sh_in   = {sh_in[6:0], mosi};
            miso_sh = {miso_sh[14:0], miso_sh[15]};
            bitc    = bitc + 1;
            if (bitc % 8 == 0) begin
                if (nb < 512) log_b[nb] = sh_in;
                nb = nb + 1;
                if (bitc == 8 && sh_in == {2'b10, LA}) miso_sh = slv_reg;
                if (bitc == 24 && log_b[nb-3] == {2'b00, LA})
                    slv_reg = {log_b[nb-2], log_b[nb-1]};
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fire(input int l);
        @(negedge clk);
        start = 1'b1;
        len   = 8'(l);
        @(negedge clk);
        start = 1'b0;
    endtask

    logic [15:0] exp_reg = 16'hB6D5;

    task automatic run_len(input int l);
        int wait_n;
        int dwidth;
        int words;
        logic [7:0] lo_exp;
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37) + l + 11);
        nb = 0;
        ntr = 0;
        fire(l);
        chk(busy === 1'b1, "R11 busy after start", busy, 1);
        wait_n = 0;
        while (done !== 1'b1 && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(err === 1'b0, "R9 accepted length no err", err, 0);
        @(negedge clk);
        dwidth = 1;
        while (done === 1'b1 && dwidth < 5) begin
            dwidth++;
            @(negedge clk);
        end
        chk(dwidth == 1, "R11 done width", dwidth, 1);
        chk(busy === 1'b0 && cs_n === 1'b1, "R1 idle after load", {busy, cs_n}, 1);
        words = (l + 1) >> 1;
        chk(ntr == 3, "R4 three select windows", ntr, 3);
        chk(tr_first[1] == 3 && tr_first[2] == 6, "R2 read window bytes", tr_first[1], 3);
        chk(log_b[0] == {2'b10, LA}, "R2 read command", log_b[0], {2'b10, LA});
        chk(log_b[3] == {2'b00, LA}, "R3 write command", log_b[3], {2'b00, LA});
        chk(log_b[4] == exp_reg[15:8], "R3 upper byte kept", log_b[4], exp_reg[15:8]);
        lo_exp = {exp_reg[7], 7'(l + 2)};
        chk(log_b[5] == lo_exp, "R3 length field", log_b[5], lo_exp);
        exp_reg = {exp_reg[15:8], lo_exp};
        chk(log_b[6] == {2'b00, RA}, "R4 burst address", log_b[6], {2'b00, RA});
        chk(nb == 7 + 2 * words, "R5 burst byte count", nb, 7 + 2 * words);
        for (int k = 0; k < words; k++) begin
            logic [7:0] hi;
            hi = (2 * k + 1 < l) ? mem[2 * k + 1] : 8'h00;
            if (2 * k + 1 >= l)
                chk(log_b[7 + 2 * k] == hi, "R7 odd pad zero", log_b[7 + 2 * k], hi);
            else
                chk(log_b[7 + 2 * k] == hi, "R6/R8 first byte", log_b[7 + 2 * k], hi);
            chk(log_b[8 + 2 * k] == mem[2 * k], "R6/R8 second byte", log_b[8 + 2 * k], mem[2 * k]);
        end
    endtask

    task automatic run_reject(input int l);
        int wait_n;
        bit saw_err;
        nb = 0;
        ntr = 0;
        saw_err = 1'b0;
        @(negedge clk);
        start = 1'b1;
        len   = 8'(l);
        @(negedge clk);
        start = 1'b0;
        saw_err = (err === 1'b1) && (done === 1'b1);
        chk(saw_err, "R9 reject flags", {err, done}, 3);
        for (wait_n = 0; wait_n < 20; wait_n++) @(negedge clk);
        chk(ntr == 0 && cs_n === 1'b1, "R9 no select on reject", ntr, 0);
        chk(err === 1'b0 && busy === 1'b0, "R9 idle after reject", {err, busy}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0,
            "R1 reset state", {cs_n, sclk, busy, done}, 8);
        for (int v = 0; v < NVEC; v++) run_len(VEC_LEN[v]);
        run_reject(126);
        run_reject(255);
        run_len(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule